// File: doc/BRIEF.md
# Restart and Stop Timing Controller

This block paces a processor's memory cycle through twelve timepulses, T01 to T12, and decides when that cycle may continue. Any of five restart causes can be raised at any time: standby, software alarm, monitor start, voltage transient and analog alarm. The block latches each one as a pending restart. It lets the current memory cycle run to its end and only then, at T12, turns the pending restart into a detected reset. From that point it drives a global restart output and a stop output. Stop holds the timepulse sequencer at T12.

The analog alarm is the high-severity cause. It raises the restart output in the same cycle and pulls the sequencer straight to T12, whatever timepulse it was on. An external halt request is a second path that does not reset anything. It lets the cycle reach T12, raises stop without raising restart, and releases stop when the request is withdrawn. Once the processor reports that its start-up sequence has been decoded, the pending and detected state clear, restart and stop fall, and the next tick moves the sequencer from T12 to T01.

Top module: `restart_stop_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `tp_onehot` is T12 (bit 11 alone set; Tk is bit k-1), `restart_out` is low and `stop_out` is low.
- R2: When stop is low, each clock with `tp_tick` high advances the timepulse one step, and T12 wraps to T01. A clock with `tp_tick` low leaves the timepulse unchanged. Exactly one bit of `tp_onehot` is ever set.
- R3: A one-clock pulse on any of `cause_req` bits 0 to 3 (bit 0 standby, bit 1 software alarm, bit 2 monitor start, bit 3 voltage transient) is latched as a pending restart. The pulse does not change `restart_out` or `stop_out` while the timepulse is not T12.
- R4: One clock after the sequencer is at T12 with a restart pending, `restart_out` and `stop_out` are both high.
- R5: While `stop_out` is high, the timepulse stays at T12 regardless of `tp_tick`.
- R6: A one-clock pulse on `startup_seq_seen`, with no cause asserted, clears the pending and detected restart. `restart_out` and `stop_out` are low after that clock, and the next tick moves the timepulse to T01. No restart appears at the following T12.
- R7: `cause_req` bit 4 (analog alarm) drives `restart_out` high in the same cycle, combinationally. After the next clock the timepulse is T12 from any phase, and a detected restart follows one clock later.
- R8: With `halt_req` held, one clock after the sequencer reaches T12 `stop_out` is high and `restart_out` stays low. One clock after `halt_req` falls, `stop_out` is low again.
- R9: A pending restart stays latched after its cause is removed, across any number of timepulses, until the start-up sequence is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tp_tick | input | 1 | Timepulse advance enable, one step per high clock |
| cause_req | input | NUM_CAUSES (5) | Restart causes; bit 4 is the high-severity analog alarm |
| halt_req | input | 1 | Halt request that stops at T12 without a reset |
| startup_seq_seen | input | 1 | Start-up sequence decoded as the current sequence |
| tp_onehot | output | TP_COUNT (12) | One-hot timepulse, bit k-1 is Tk |
| restart_out | output | 1 | Global restart |
| stop_out | output | 1 | Stop; freezes the sequencer at T12 |

## Verification
The bench builds the block with its default parameters: twelve timepulses and five causes. At these values every cause bit, including the analog-alarm position at the top index, can be driven at an early, a middle and a late phase of the cycle. The full twelve-step wrap and the hold at the last phase can then be checked against hand-counted tick numbers. Each deferred cause is injected at a different phase, so that the count of ticks to T12 differs for each. The analog-alarm and halt paths run from mid-cycle.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int DEF_TP_COUNT   = 12;
    localparam int DEF_NUM_CAUSES = 5;

    // Cause positions on the request vector; the last one is high severity.
    typedef enum logic [2:0] {
        CAUSE_STANDBY        = 3'd0,
        CAUSE_SW_ALARM       = 3'd1,
        CAUSE_MON_START      = 3'd2,
        CAUSE_VOLT_TRANSIENT = 3'd3,
        CAUSE_ANALOG         = 3'd4
    } cause_e;

    // Restart state carried between the latch stages.
    typedef struct packed {
        logic pending;
        logic detected;
    } restart_state_t;

    function automatic logic any_set(input logic [DEF_NUM_CAUSES-1:0] v);
        return |v;
    endfunction

endpackage

// File: rtl/tp_sequencer.sv
module tp_sequencer #(
    parameter int TP_COUNT = rsc_pkg::DEF_TP_COUNT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                hold_last,
    input  logic                force_last,
    output logic [TP_COUNT-1:0] tp_o,
    output logic                at_last_o
);
    localparam int LAST = TP_COUNT - 1;
    localparam logic [TP_COUNT-1:0] LAST_VEC = {1'b1, {(TP_COUNT-1){1'b0}}};

    logic [TP_COUNT-1:0] tp_q;
    logic                advance;

    assign advance = tick && !(tp_q[LAST] && hold_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            tp_q <= LAST_VEC;
        end else if (force_last) begin
            tp_q <= LAST_VEC;
        end else if (advance) begin
            tp_q <= {tp_q[LAST-1:0], tp_q[LAST]};
        end
    end

    assign tp_o      = tp_q;
    assign at_last_o = tp_q[LAST];

    p_one_phase_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(tp_q) == 1);

    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && tp_q[LAST] && !hold_last && !force_last) |=> tp_q[0]);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (tp_q[LAST] && hold_last) |=> tp_q[LAST]);

    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !force_last) |=> $stable(tp_q));

endmodule

// File: rtl/restart_tracker.sv
module restart_tracker #(
    parameter int NUM_CAUSES = rsc_pkg::DEF_NUM_CAUSES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CAUSES-1:0] cause_i,
    input  logic                  at_last,
    input  logic                  seq_seen,
    output logic                  pending_o,
    output logic                  detected_o
);
    rsc_pkg::restart_state_t st_q, st_d;
    logic any_cause;

    assign any_cause = |cause_i;

    always_comb begin
        st_d.pending  = any_cause || (st_q.pending && !seq_seen);
        st_d.detected = !seq_seen && (st_q.detected || (st_q.pending && at_last));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_o  = st_q.pending;
    assign detected_o = st_q.detected;

    p_detect_at_last_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.detected) |-> $past(at_last && st_q.pending));

    p_pending_kept_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q.pending && !seq_seen) |=> st_q.pending);

    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        (seq_seen && !any_cause) |=> (!st_q.pending && !st_q.detected));

endmodule

// File: rtl/halt_tracker.sv
module halt_tracker (
    input  logic clk,
    input  logic rst,
    input  logic halt_req,
    input  logic at_last,
    output logic halt_o
);
    logic halt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= 1'b0;
        end else if (!halt_req) begin
            halt_q <= 1'b0;
        end else if (at_last) begin
            halt_q <= 1'b1;
        end
    end

    assign halt_o = halt_q;

    p_halt_at_last_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_q) |-> $past(at_last));

    p_halt_drop_r8: assert property (@(posedge clk) disable iff (rst)
        !halt_req |=> !halt_q);

endmodule

// File: rtl/restart_stop_ctrl.sv
module restart_stop_ctrl #(
    parameter int TP_COUNT   = rsc_pkg::DEF_TP_COUNT,
    parameter int NUM_CAUSES = rsc_pkg::DEF_NUM_CAUSES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tp_tick,
    input  logic [NUM_CAUSES-1:0] cause_req,
    input  logic                  halt_req,
    input  logic                  startup_seq_seen,
    output logic [TP_COUNT-1:0]   tp_onehot,
    output logic                  restart_out,
    output logic                  stop_out
);
    localparam int ANALOG_IDX = NUM_CAUSES - 1;

    logic at_last;
    logic pending;
    logic detected;
    logic halted;
    logic hold_last;
    logic analog;

    assign analog = cause_req[ANALOG_IDX];

    // A request that is due at the last phase must hold it already in the
    // cycle before its stage register reports it.
    assign hold_last = detected || halted || pending || halt_req;

    tp_sequencer #(.TP_COUNT(TP_COUNT)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tp_tick),
        .hold_last  (hold_last),
        .force_last (analog),
        .tp_o       (tp_onehot),
        .at_last_o  (at_last)
    );

    restart_tracker #(.NUM_CAUSES(NUM_CAUSES)) u_rst_trk (
        .clk        (clk),
        .rst        (rst),
        .cause_i    (cause_req),
        .at_last    (at_last),
        .seq_seen   (startup_seq_seen),
        .pending_o  (pending),
        .detected_o (detected)
    );

    halt_tracker u_halt_trk (
        .clk      (clk),
        .rst      (rst),
        .halt_req (halt_req),
        .at_last  (at_last),
        .halt_o   (halted)
    );

    assign restart_out = detected || analog;
    assign stop_out    = detected || halted;

    p_analog_last_r7: assert property (@(posedge clk) disable iff (rst)
        analog |=> tp_onehot[TP_COUNT-1]);

    p_stop_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        stop_out |=> tp_onehot[TP_COUNT-1]);

    p_restart_stops_r4: assert property (@(posedge clk) disable iff (rst)
        (restart_out && !analog) |-> stop_out);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (tp_onehot[TP_COUNT-1] && !stop_out));

endmodule

// File: tb/restart_stop_ctrl_bench.sv
module restart_stop_ctrl_bench;
    localparam int TPN = 12;
    localparam int NC  = 5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           tp_tick = 1'b0;
    logic [NC-1:0]  cause_req = '0;
    logic           halt_req = 1'b0;
    logic           startup_seq_seen = 1'b0;
    logic [TPN-1:0] tp_onehot;
    logic           restart_out;
    logic           stop_out;

    int n_checks = 0;
    int n_bad    = 0;

    // Each entry: cause index [6:4], phase Tk reached before the pulse [3:0].
    localparam logic [6:0] VECS [4] = '{
        {3'd0, 4'd3}, {3'd1, 4'd7}, {3'd2, 4'd11}, {3'd3, 4'd1}
    };

    always #2 clk = ~clk;

    restart_stop_ctrl u_restart_stop_ctrl (
        .clk(clk), .rst(rst), .tp_tick(tp_tick), .cause_req(cause_req),
        .halt_req(halt_req), .startup_seq_seen(startup_seq_seen),
        .tp_onehot(tp_onehot), .restart_out(restart_out), .stop_out(stop_out)
    );

    function automatic logic [TPN-1:0] tp_of(input int k);
        return TPN'(1) << (k - 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tp_tick = 1'b1;
            @(negedge clk);
            tp_tick = 1'b0;
        end
    endtask

    task automatic decode();
        startup_seq_seen = 1'b1;
        @(negedge clk);
        startup_seq_seen = 1'b0;
    endtask

    initial begin
        #800000;
        n_bad++;
        n_checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R1 reset tp", tp_onehot, tp_of(12));
        chk("R1 reset restart", restart_out, 0);
        chk("R1 reset stop", stop_out, 0);
        do_reset();
        chk("R1 after reset tp", tp_onehot, tp_of(12));

        // R2: walk and wrap
        for (int k = 1; k <= 13; k++) begin
            ticks(1);
            chk("R2 step", tp_onehot, tp_of(((k - 1) % 12) + 1));
        end
        repeat (2) @(negedge clk);
        chk("R2 no tick", tp_onehot, tp_of(1));

        // Deferred causes from the vector table
        for (int v = 0; v < 4; v++) begin
            int c;
            int k;
            c = int'(VECS[v][6:4]);
            k = int'(VECS[v][3:0]);
            do_reset();
            ticks(k);
            chk("R2 phase", tp_onehot, tp_of(k));
            cause_req[c] = 1'b1;
            @(negedge clk);
            cause_req = '0;
            chk("R3 restart deferred", restart_out, 0);
            chk("R3 stop deferred", stop_out, 0);
            chk("R3 tp kept", tp_onehot, tp_of(k));
            ticks(12 - k);
            chk("R9 reached T12", tp_onehot, tp_of(12));
            @(negedge clk);
            chk("R4 restart", restart_out, 1);
            chk("R4 stop", stop_out, 1);
            ticks(3);
            chk("R5 held at T12", tp_onehot, tp_of(12));
            chk("R5 stop kept", stop_out, 1);
            decode();
            chk("R6 restart released", restart_out, 0);
            chk("R6 stop released", stop_out, 0);
            ticks(1);
            chk("R6 to T01", tp_onehot, tp_of(1));
            ticks(11);
            @(negedge clk);
            chk("R6 no repeat restart", restart_out, 0);
        end

        // R7: analog alarm from mid cycle
        do_reset();
        ticks(5);
        cause_req[rsc_pkg::CAUSE_ANALOG] = 1'b1;
        #1;
        chk("R7 restart immediate", restart_out, 1);
        @(negedge clk);
        cause_req = '0;
        chk("R7 forced T12", tp_onehot, tp_of(12));
        @(negedge clk);
        chk("R7 detected restart", restart_out, 1);
        chk("R7 stop", stop_out, 1);
        decode();
        ticks(1);
        chk("R7 resume T01", tp_onehot, tp_of(1));

        // R8: halt without reset
        do_reset();
        ticks(5);
        halt_req = 1'b1;
        @(negedge clk);
        chk("R8 no stop mid cycle", stop_out, 0);
        ticks(7);
        chk("R8 at T12", tp_onehot, tp_of(12));
        @(negedge clk);
        chk("R8 stop", stop_out, 1);
        chk("R8 no restart", restart_out, 0);
        ticks(2);
        chk("R8 held", tp_onehot, tp_of(12));
        halt_req = 1'b0;
        @(negedge clk);
        chk("R8 stop released", stop_out, 0);
        ticks(1);
        chk("R8 resume T01", tp_onehot, tp_of(1));

        // R1: reset while stopped by a restart
        cause_req[rsc_pkg::CAUSE_ANALOG] = 1'b1;
        @(negedge clk);
        cause_req = '0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset clears stop", stop_out, 0);
        chk("R1 reset clears restart", restart_out, 0);
        rst = 1'b0;
        @(negedge clk);
        ticks(1);
        chk("R1 runs after reset", tp_onehot, tp_of(1));

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule